// File: doc/BRIEF.md
# Two-Channel Bus-Master DMA Register File

This block holds the control registers that a host uses to run bus-master DMA on a two-channel disk controller. Each channel has a command byte, a status byte and a 32-bit descriptor-table pointer. The host reaches them over a byte-addressed register bus with one request per cycle. The block checks each access for a legal size and alignment and applies the per-field rules: the active flag cannot be written, the direction bit is locked while a transfer runs, and the interrupt flag is write-one-to-clear.

Setting the start bit sends a one-cycle start pulse to that channel's transfer engine, and the engine reads the table base from the pointer output. Clearing the start bit sends a stop pulse. When an engine finishes, it pulses its completion input. The channel then leaves the running state and raises its interrupt flag in one step. Two enables gate the register bus. One turns off all decoding. The other blocks writes while bus mastering is turned off.

The 16-byte map is laid out by channel. The channel is `req_addr[3]`, and `req_addr[2:0]` selects the field within the channel:
- offset 0 is the command byte;
- offset 2 is the status byte;
- offsets 4 to 7 hold the pointer, least significant byte first;
- offsets 1 and 3 are padding.

Top module: `bm_dma_regs`

## Requirements
- R1: After reset, both status bytes read 0x60 (capability bits 5 and 6 set), and every other byte reads zero.
- R2: A read request with req_size 0, 1 or 2 (8, 16 or 32 bits) is aligned when its address is a multiple of its size. An aligned read with io_en high returns, one cycle later, rd_valid high and rd_data holding the addressed bytes in little-endian order. Unused upper bits and padding bytes read as zero.
- R3: A command-byte write that changes the start bit (bit 0) from 0 to 1 sets active (status bit 0). On the next cycle it pulses start_pulse for that channel, and table_base shows that channel's pointer.
- R4: A command-byte write that changes the start bit from 1 to 0 clears active and pulses stop_pulse for that channel on the next cycle.
- R5: The command byte keeps only bit 0 (start) and bit 3 (direction), and other bits read as zero. While start is already set, a command write leaves the direction bit unchanged.
- R6: A status-byte write updates bits 5 and 6 from the data and leaves the active bit unchanged.
- R7: The interrupt flag (status bit 2) clears when a 1 is written to it and is unchanged when a 0 is written.
- R8: A done pulse for a channel clears its start bit and active bit and sets its interrupt flag. It overrides a register write to the same channel in the same cycle.
- R9: A 32-bit write at pointer offset 4 stores the data with bits 1:0 forced to zero.
- R10: The only legal writes are a byte at offset 0 or 2, or a 32-bit word at offset 4. Any other write, and any read with req_size 3 or a misaligned address, changes nothing and raises err for one cycle.
- R11: While bm_en is low, writes change no register, emit no pulse and raise no err. Reads still work.
- R12: While io_en is low, no access changes state, and rd_valid and err stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | Register decoding enable |
| bm_en | input | 1 | Bus-master enable; gates writes |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address within the map |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_wdata | input | 32 | Write data, little-endian |
| done | input | 2 | Per-channel transfer-complete pulse |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_data | output | 32 | Read data |
| err | output | 1 | Illegal-access flag, one cycle |
| start_pulse | output | 2 | Per-channel DMA start pulse |
| stop_pulse | output | 2 | Per-channel DMA stop pulse |
| table_base | output | 64 | Channel 1 and channel 0 descriptor pointers, channel 0 in bits 31:0 |

## Verification
The properties assume the completion inputs are pulses that an engine raises only for its own channel. A completion in the same cycle as a start write is exempt from the start-sets-active property, because the completion wins (R8). Reset is treated as synchronous and held for several cycles. The stimulus issues at most one request per cycle and drives every input between clock edges. It applies done only to model a finishing transfer, including one case where done meets a stop write on the same channel.

// File: rtl/bm_dma_regs.sv
module bm_dma_regs #(
  parameter int PTR_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_en,
  input  logic               bm_en,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [3:0]         req_addr,
  input  logic [1:0]         req_size,
  input  logic [31:0]        req_wdata,
  input  logic [1:0]         done,
  output logic               rd_valid,
  output logic [31:0]        rd_data,
  output logic               err,
  output logic [1:0]         start_pulse,
  output logic [1:0]         stop_pulse,
  output logic [2*PTR_W-1:0] table_base
);
  localparam logic [7:0] CAP_RESET = 8'h60;

  logic [7:0]       cmd_q [2];
  logic [7:0]       sts_q [2];
  logic [PTR_W-1:0] ptr_q [2];
  logic [7:0]       cmd_d [2];
  logic [7:0]       sts_d [2];
  logic [PTR_W-1:0] ptr_d [2];
  logic [1:0]       go, halt;

  wire [2:0] off = req_addr[2:0];
  wire       ch  = req_addr[3];
  wire       live = req_valid && io_en;

  wire wr_legal = ((off == 3'd0 || off == 3'd2) && req_size == 2'd0) ||
                  (off == 3'd4 && req_size == 2'd2);
  wire rd_legal = (req_size == 2'd0) ||
                  (req_size == 2'd1 && !req_addr[0]) ||
                  (req_size == 2'd2 && req_addr[1:0] == 2'b00);

  wire wr_fire = live && req_write && bm_en && wr_legal;
  wire rd_fire = live && !req_write && rd_legal;
  wire bad     = live && (req_write ? (bm_en && !wr_legal) : !rd_legal);

  function automatic logic [7:0] byte_at(input logic [3:0] a);
    logic c;
    c = a[3];
    case (a[2:0])
      3'd0:    byte_at = cmd_q[c];
      3'd2:    byte_at = sts_q[c];
      3'd4:    byte_at = ptr_q[c][7:0];
      3'd5:    byte_at = ptr_q[c][15:8];
      3'd6:    byte_at = ptr_q[c][23:16];
      3'd7:    byte_at = ptr_q[c][31:24];
      default: byte_at = 8'h00;
    endcase
  endfunction

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      cmd_d[c] = cmd_q[c];
      sts_d[c] = sts_q[c];
      ptr_d[c] = ptr_q[c];
      go[c]    = 1'b0;
      halt[c]  = 1'b0;
      if (wr_fire && ch == c[0]) begin
        case (off)
          3'd0: begin
            cmd_d[c] = req_wdata[7:0] & 8'h09;
            if (cmd_q[c][0]) cmd_d[c][3] = cmd_q[c][3];
            if (!cmd_q[c][0] && cmd_d[c][0]) begin
              go[c] = 1'b1;
              sts_d[c][0] = 1'b1;
            end
            if (cmd_q[c][0] && !cmd_d[c][0]) begin
              halt[c] = 1'b1;
              sts_d[c][0] = 1'b0;
            end
          end
          3'd2: sts_d[c] = {1'b0, req_wdata[6:5], 2'b00,
                            sts_q[c][2] & ~req_wdata[2], 1'b0, sts_q[c][0]};
          default: ptr_d[c] = {req_wdata[PTR_W-1:2], 2'b00};
        endcase
      end
      if (done[c]) begin
        cmd_d[c][0] = 1'b0;
        sts_d[c][0] = 1'b0;
        sts_d[c][2] = 1'b1;
      end
    end
  end

  logic [31:0] rd_d;
  always_comb begin
    rd_d = '0;
    for (int i = 0; i < 4; i++)
      if (i < (1 << req_size)) rd_d[8*i +: 8] = byte_at(req_addr + 4'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        cmd_q[c] <= '0;
        sts_q[c] <= CAP_RESET;
        ptr_q[c] <= '0;
      end
      start_pulse <= '0;
      stop_pulse  <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      err         <= 1'b0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        cmd_q[c] <= cmd_d[c];
        sts_q[c] <= sts_d[c];
        ptr_q[c] <= ptr_d[c];
      end
      start_pulse <= go;
      stop_pulse  <= halt;
      rd_valid    <= rd_fire;
      if (rd_fire) rd_data <= rd_d;
      err         <= bad;
    end
  end

  assign table_base = {ptr_q[1], ptr_q[0]};
endmodule

// File: rtl/bm_dma_regs_checker.sv
module bm_dma_regs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        io_en,
  input logic        bm_en,
  input logic [1:0]  done,
  input logic [1:0]  start_pulse,
  input logic [1:0]  stop_pulse,
  input logic        err,
  input logic        rd_valid,
  input logic [15:0] cmd_flat,
  input logic [15:0] sts_flat,
  input logic [63:0] ptr_flat
);
  for (genvar c = 0; c < 2; c++) begin : g_ch
    a_r3_start_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
      (start_pulse[c] && !$past(done[c])) |-> sts_flat[8*c]);
    a_r4_no_start_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_pulse[c] && stop_pulse[c]));
    a_r5_dir_locked: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_flat[8*c] |=> cmd_flat[8*c+3] == $past(cmd_flat[8*c+3]));
    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      done[c] |=> (!cmd_flat[8*c] && !sts_flat[8*c] && sts_flat[8*c+2]));
  end
  a_r11_bm_off_ptr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !bm_en |=> $stable(ptr_flat));
  a_r12_io_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !io_en |=> (!err && !rd_valid));
  a_r10_err_not_with_read: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rd_valid);
endmodule

bind bm_dma_regs bm_dma_regs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .io_en(io_en), .bm_en(bm_en), .done(done),
  .start_pulse(start_pulse), .stop_pulse(stop_pulse), .err(err),
  .rd_valid(rd_valid),
  .cmd_flat({cmd_q[1], cmd_q[0]}),
  .sts_flat({sts_q[1], sts_q[0]}),
  .ptr_flat({ptr_q[1], ptr_q[0]})
);

// File: tb/bm_dma_regs_test.sv
module bm_dma_regs_test;
  logic        clk = 0, rst_n = 0, io_en = 1, bm_en = 1;
  logic        req_valid = 0, req_write = 0;
  logic [3:0]  req_addr = 0;
  logic [1:0]  req_size = 0;
  logic [31:0] req_wdata = 0;
  logic [1:0]  done = 0;
  logic        rd_valid, err;
  logic [31:0] rd_data;
  logic [1:0]  start_pulse, stop_pulse;
  logic [63:0] table_base;

  bm_dma_regs uut (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  string cur = "R1";
  byte unsigned mem [16];
  bit e_rdv, e_err;
  bit [1:0] e_st, e_sp;
  bit [31:0] e_rd;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", cur, what, act, exp);
    end
  endtask

  function automatic bit [31:0] ptr_of(int c);
    return {mem[8*c+7], mem[8*c+6], mem[8*c+5], mem[8*c+4]};
  endfunction

  task automatic model();
    int a = req_addr, o = req_addr % 8, b = (req_addr / 8) * 8, n = 1 << req_size;
    bit wl = ((o == 0 || o == 2) && req_size == 0) || (o == 4 && req_size == 2);
    bit rl = req_size != 3 && (a % n == 0);
    e_rdv = 0; e_err = 0; e_st = 0; e_sp = 0;
    if (req_valid && io_en) begin
      if (req_write) begin
        if (bm_en && !wl) e_err = 1;
        else if (bm_en) begin
          if (o == 0) begin
            byte unsigned old = mem[a];
            byte unsigned nv = req_wdata[7:0] & 8'h09;
            if (old & 1) nv = (nv & 8'hF7) | (old & 8'h08);
            if (!(old & 1) && (nv & 1)) begin mem[b+2] |= 1; e_st[b/8] = 1; end
            if ((old & 1) && !(nv & 1)) begin mem[b+2] &= 8'hFE; e_sp[b/8] = 1; end
            mem[a] = nv;
          end else if (o == 2) begin
            byte unsigned old = mem[a];
            mem[a] = (req_wdata[7:0] & 8'h60) | (old & 1) | (old & 4 & ~req_wdata[7:0]);
          end else
            for (int i = 0; i < 4; i++) mem[a+i] = (req_wdata & 32'hFFFF_FFFC) >> (8*i);
        end
      end else if (!rl) e_err = 1;
      else begin
        e_rdv = 1; e_rd = 0;
        for (int i = 0; i < n; i++) e_rd |= 32'(mem[a+i]) << (8*i);
      end
    end
    for (int c = 0; c < 2; c++)
      if (done[c]) begin
        mem[8*c] &= 8'hFE;
        mem[8*c+2] = (mem[8*c+2] & 8'hFE) | 4;
      end
  endtask

  task automatic compare();
    chk("rd_valid", rd_valid, e_rdv);
    if (e_rdv) chk("rd_data", rd_data, e_rd);
    chk("err", err, e_err);
    chk("start_pulse", start_pulse, e_st);
    chk("stop_pulse", stop_pulse, e_sp);
    for (int c = 0; c < 2; c++)
      if (e_st[c]) chk("table_base", table_base[32*c +: 32], ptr_of(c));
  endtask

  task automatic cyc(bit v, bit w, int a, int s, bit [31:0] d, bit [1:0] dn = 0);
    req_valid = v; req_write = w; req_addr = 4'(a); req_size = 2'(s);
    req_wdata = d; done = dn;
    @(posedge clk);
    model();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(int a, int s, bit [31:0] d); cyc(1, 1, a, s, d); endtask
  task automatic rd(int a, int s); cyc(1, 0, a, s, 0); endtask
  task automatic idle(bit [1:0] dn = 0); cyc(0, 0, 0, 0, 0, dn); endtask

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    foreach (mem[i]) mem[i] = 0;
    mem[2] = 8'h60; mem[10] = 8'h60;
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur = "R1"; rd(0, 2); rd(8, 2); rd(4, 2); rd(12, 2);
    cur = "R9"; wr(4, 2, 32'h1234_5677); wr(12, 2, 32'hCAFE_F00D);
    cur = "R2"; rd(4, 2); rd(6, 1); rd(7, 0); rd(2, 1); rd(12, 1); rd(1, 0);
    cur = "R3"; wr(0, 0, 32'h0000_0009); idle(); rd(0, 2);
    cur = "R5"; wr(0, 0, 32'hFF); rd(0, 0); wr(0, 0, 32'h01); rd(0, 0);
    cur = "R6"; wr(2, 0, 32'h00); rd(2, 0); wr(2, 0, 32'h60);
    cur = "R4"; wr(0, 0, 32'h00); rd(2, 0); wr(0, 0, 32'h08); rd(0, 0);
    cur = "R3"; wr(8, 0, 32'h01); rd(8, 2);
    cur = "R8"; idle(2'b10); rd(8, 2); rd(10, 0);
    cur = "R7"; wr(10, 0, 32'h60); rd(10, 0); wr(10, 0, 32'h64); rd(10, 0);
    cur = "R8"; wr(0, 0, 32'h01); cyc(1, 1, 0, 0, 32'h00, 2'b01); rd(0, 2);
    cur = "R10"; rd(0, 3); rd(1, 1); rd(2, 2); wr(0, 1, 32'h01); wr(4, 0, 32'h55);
    wr(1, 0, 32'h01); wr(8, 2, 32'h01); rd(0, 2); rd(4, 2);
    cur = "R11"; bm_en = 0; wr(0, 0, 32'h01); wr(12, 2, 32'h0); wr(0, 3, 0);
    rd(0, 2); rd(12, 2); bm_en = 1;
    cur = "R12"; io_en = 0; rd(0, 2); wr(0, 0, 32'h01); rd(0, 3); io_en = 1;
    rd(0, 2);
    idle();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule